// File: doc/BRIEF.md
# Programmable-Format Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A character written by the host waits in a holding stage and moves into a frame shifter as soon as the shifter is idle. The shifter sends a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a stop period. The line idles high. A one-cycle enable from an external baud divider paces the shifter, and one bit lasts sixteen of those enables.

A 7-bit control word sets the frame format. It selects the word length, the stop length, the parity kind and a break request. The shifter captures the format when a character enters it, so the host can change the control word at any time without corrupting a frame in flight. The holding stage is either a single register or a 32-entry first-in-first-out queue, chosen by a mode input. Two status outputs report that the holding stage is empty and that the whole transmitter is empty.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset `tx_out` is 1 and both `hold_empty` and `all_empty` are 1.
- R2: A frame is a 0 start bit, the data bits least significant first, the optional parity bit and a stop period at level 1. Every bit lasts 16 cycles in which `baud_tick` is 1. Cycles with `baud_tick` at 0 do not advance the frame.
- R3: `line_ctrl[1:0]` sets the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Only that many low-order bits of the byte are sent.
- R4: With `line_ctrl[2]`=0 the stop period is 16 ticks. With `line_ctrl[2]`=1 it is 24 ticks for 5-bit words and 32 ticks for 6-, 7- and 8-bit words.
- R5: `line_ctrl[3]`=0 sends no parity bit. When it is 1, `line_ctrl[5:4]` picks the parity bit: 00 makes the count of ones over data and parity odd, 01 makes it even, 10 sends a constant 1 and 11 sends a constant 0.
- R6: While `line_ctrl[6]` is 1, `tx_out` is 0 in the same cycle. Frame timing keeps running underneath, and clearing the bit restores the frame's current level.
- R7: The format in effect for a frame is the value of `line_ctrl[5:0]` at the clock edge where the character enters the shifter. Later changes affect only later frames.
- R8: `hold_empty` goes to 0 in the cycle after a write is accepted. It returns to 1 in the cycle after the last held character moves into the shifter.
- R9: `all_empty` is 1 only when the holding stage holds nothing and no frame is in progress.
- R10: With `fifo_mode`=0 the holding stage keeps one byte. With `fifo_mode`=1 it keeps up to 32 bytes and sends them in write order. A write is accepted only when the stage holds fewer bytes than its capacity at that clock edge, counted before any move into the shifter on the same edge. Other writes are dropped.
- R11: A held character enters the shifter on the first clock edge at which the shifter is idle, without waiting for `baud_tick`. The start bit appears on `tx_out` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pacing enable, 16 per bit time |
| line_ctrl | input | 7 | Frame format [5:0] and break request [6] |
| fifo_mode | input | 1 | 0: single holding register, 1: 32-entry queue |
| wr_en | input | 1 | Write strobe for a new character |
| wr_data | input | 8 | Character to send |
| tx_out | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding stage empty |
| all_empty | output | 1 | Holding stage and shifter both empty |

## Verification
The hardest case to reach from the ports is a write arriving on the same edge that a held byte moves into the shifter. In this case acceptance depends on the occupancy before the move. The bench creates it with back-to-back writes in single-register mode. It also fills the queue past capacity while a long frame is running, then counts the frames that come out on the line. To make the frame count a port observation, the payload bits in that burst are all zero, so each frame gives exactly one falling edge. The mid-frame cases (a break request, and a format change while a character is in flight) are timed by cycle counts from the write. The whole line is compared against a tick-level queue model on every clock.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] wsel;
        logic       long_stop;
        logic       par_on;
        logic       par_even;
        logic       par_stick;
    } tx_fmt_t;

    function automatic tx_fmt_t fmt_decode(input logic [5:0] ctl);
        tx_fmt_t f;
        f.wsel      = ctl[1:0];
        f.long_stop = ctl[2];
        f.par_on    = ctl[3];
        f.par_even  = ctl[4];
        f.par_stick = ctl[5];
        return f;
    endfunction

    function automatic logic [3:0] word_bits(input logic [1:0] wsel);
        return 4'd5 + {2'b00, wsel};
    endfunction

    function automatic logic [7:0] word_mask(input logic [1:0] wsel);
        return 8'hFF >> (2'd3 - wsel);
    endfunction

endpackage

// File: rtl/tx_hold_fifo.sv
module tx_hold_fifo #(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_mode,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          pop,
    output logic [DW-1:0] rd_data,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] cap;
    logic          accept;
    logic          do_pop;

    assign cap     = fifo_mode ? CW'(DEPTH) : CW'(1);
    assign accept  = wr_en && (q.cnt < cap);
    assign do_pop  = pop && (q.cnt != '0);
    assign empty   = (q.cnt == '0);
    assign rd_data = mem[q.rd];

    always_comb begin
        d = q;
        if (accept) begin
            d.wr = (q.wr == AW'(DEPTH - 1)) ? '0 : q.wr + 1'b1;
        end
        if (do_pop) begin
            d.rd = (q.rd == AW'(DEPTH - 1)) ? '0 : q.rd + 1'b1;
        end
        case ({accept, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[q.wr] <= wr_data;
        end
    end

    // R10
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (q.cnt >= cap) && !pop) |=> $stable(q.cnt));

    // R8
    wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (q.cnt < cap)) |=> !empty);

endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
    import uart_tx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    baud_tick,
    input  tx_fmt_t fmt_in,
    input  logic    load,
    input  logic [7:0] load_data,
    output logic    idle,
    output logic    line
);
    localparam int TW = $clog2(2 * OVS);

    typedef struct packed {
        tx_state_e  st;
        logic [TW-1:0] tick;
        logic [2:0] idx;
        logic [7:0] shreg;
        logic       par_bit;
        tx_fmt_t    fmt;
    } sh_st_t;

    sh_st_t q, d;
    logic [TW-1:0] stop_last;
    logic [TW-1:0] bit_last;
    logic [TW-1:0] cur_last;
    logic [3:0]    nbits;
    logic [7:0]    masked;
    logic          ones_odd;
    logic          new_par;

    always_comb begin
        masked   = load_data & word_mask(fmt_in.wsel);
        ones_odd = ^masked;
        if (fmt_in.par_stick) begin
            new_par = ~fmt_in.par_even;
        end else if (fmt_in.par_even) begin
            new_par = ones_odd;
        end else begin
            new_par = ~ones_odd;
        end
    end

    always_comb begin
        nbits    = word_bits(q.fmt.wsel);
        bit_last = TW'(OVS - 1);
        if (!q.fmt.long_stop) begin
            stop_last = TW'(OVS - 1);
        end else if (q.fmt.wsel == 2'd0) begin
            stop_last = TW'((OVS * 3) / 2 - 1);
        end else begin
            stop_last = TW'(2 * OVS - 1);
        end
        cur_last = (q.st == ST_STOP) ? stop_last : bit_last;
    end

    always_comb begin
        d = q;
        if (q.st == ST_IDLE) begin
            if (load) begin
                d.st      = ST_START;
                d.tick    = '0;
                d.idx     = '0;
                d.shreg   = load_data;
                d.fmt     = fmt_in;
                d.par_bit = new_par;
            end
        end else if (baud_tick) begin
            if (q.tick != cur_last) begin
                d.tick = q.tick + 1'b1;
            end else begin
                d.tick = '0;
                unique case (q.st)
                    ST_START: d.st = ST_DATA;
                    ST_DATA: begin
                        d.shreg = q.shreg >> 1;
                        d.idx   = q.idx + 1'b1;
                        if ({1'b0, q.idx} == nbits - 4'd1) begin
                            d.st = q.fmt.par_on ? ST_PAR : ST_STOP;
                        end
                    end
                    ST_PAR:  d.st = ST_STOP;
                    ST_STOP: d.st = ST_IDLE;
                    default: d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, tick: '0, idx: '0, shreg: '0, par_bit: 1'b0, fmt: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (q.st)
            ST_START: line = 1'b0;
            ST_DATA:  line = q.shreg[0];
            ST_PAR:   line = q.par_bit;
            default:  line = 1'b1;
        endcase
    end

    assign idle = (q.st == ST_IDLE);

    // R2
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick && q.st != ST_IDLE) |=> $stable(q.tick));

    // R3
    data_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DATA) |-> ({1'b0, q.idx} < word_bits(q.fmt.wsel)));

    // R7
    fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> (q.st == ST_IDLE || $stable(q.fmt)));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int OVS   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic [6:0] line_ctrl,
    input  logic       fifo_mode,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       tx_out,
    output logic       hold_empty,
    output logic       all_empty
);
    logic       fifo_empty;
    logic [7:0] head_data;
    logic       sh_idle;
    logic       sh_line;
    logic       move;
    tx_fmt_t    fmt_now;

    assign fmt_now = fmt_decode(line_ctrl[5:0]);
    assign move    = sh_idle && !fifo_empty;

    tx_hold_fifo #(
        .DEPTH (DEPTH),
        .DW    (8)
    ) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_mode (fifo_mode),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .pop       (move),
        .rd_data   (head_data),
        .empty     (fifo_empty)
    );

    tx_frame_shifter #(
        .OVS (OVS)
    ) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .fmt_in    (fmt_now),
        .load      (move),
        .load_data (head_data),
        .idle      (sh_idle),
        .line      (sh_line)
    );

    assign tx_out     = sh_line & ~line_ctrl[6];
    assign hold_empty = fifo_empty;
    assign all_empty  = fifo_empty & sh_idle;

    // R11
    load_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_empty && sh_idle) |=> !sh_idle);

    // R9
    busy_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (all_empty && !line_ctrl[6]) |-> tx_out);

endmodule

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [6:0] line_ctrl = 7'h03;
    logic       fifo_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_out, hold_empty, all_empty;

    always #10 clk = ~clk;

    uart_frame_tx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .line_ctrl  (line_ctrl),
        .fifo_mode  (fifo_mode),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .tx_out     (tx_out),
        .hold_empty (hold_empty),
        .all_empty  (all_empty)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    int    tick_per = 1;
    int    tick_ctr = 0;
    int    falls = 0;
    bit    prev_tx = 1'b1;
    bit    finished = 1'b0;

    // reference model: queued bytes, and per-tick levels of the frame in flight
    byte unsigned mq[$];
    bit           lv[$];
    bit           busy = 1'b0;

    function automatic void build_frame(input logic [7:0] b, input logic [6:0] c);
        int n;
        int ones;
        bit p;
        int stop_ticks;
        n = 5 + int'(c[1:0]);
        ones = 0;
        for (int k = 0; k < 16; k++) lv.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
            ones += int'(b[i]);
            for (int k = 0; k < 16; k++) lv.push_back(b[i]);
        end
        if (c[3]) begin
            if (c[5]) p = !c[4];
            else if (c[4]) p = (ones % 2) == 1;
            else p = (ones % 2) == 0;
            for (int k = 0; k < 16; k++) lv.push_back(p);
        end
        stop_ticks = c[2] ? ((n == 5) ? 24 : 32) : 16;
        for (int k = 0; k < stop_ticks; k++) lv.push_back(1'b1);
    endfunction

    always @(posedge clk) begin : ref_model
        int  pre_size;
        bit  pre_busy;
        int  cap;
        byte unsigned b;
        if (!rst_n) begin
            mq.delete();
            lv.delete();
            busy = 1'b0;
        end else begin
            cap      = fifo_mode ? 32 : 1;
            pre_size = mq.size();
            pre_busy = busy;
            if (pre_busy && baud_tick) begin
                void'(lv.pop_front());
                if (lv.size() == 0) busy = 1'b0;
            end
            if (!pre_busy && pre_size > 0) begin
                b = mq.pop_front();
                build_frame(b, line_ctrl);
                busy = 1'b1;
            end
            if (wr_en && pre_size < cap) mq.push_back(wr_data);
        end
    end

    function automatic bit exp_tx();
        if (line_ctrl[6]) return 1'b0;
        if (busy) return lv[0];
        return 1'b1;
    endfunction

    task automatic chk(input string t, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", t, act, exp);
        end
    endtask

    task automatic step();
        bit e_tx, e_he, e_ae;
        @(negedge clk);
        e_tx = exp_tx();
        e_he = (mq.size() == 0);
        e_ae = (mq.size() == 0) && !busy;
        checks++;
        if (tx_out !== e_tx || hold_empty !== e_he || all_empty !== e_ae) begin
            errors++;
            $display("FAIL %s: tx/hold/all actual %b%b%b expected %b%b%b at %0t",
                     tag, tx_out, hold_empty, all_empty, e_tx, e_he, e_ae, $time);
        end
        if (prev_tx && !tx_out) falls++;
        prev_tx = tx_out;
        if (tick_ctr + 1 >= tick_per) begin
            baud_tick = 1'b1;
            tick_ctr = 0;
        end else begin
            baud_tick = 1'b0;
            tick_ctr++;
        end
    endtask

    task automatic send(input logic [7:0] b);
        wr_data = b;
        wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while ((busy || mq.size() != 0) && n < 30000) begin
            step();
            n++;
        end
        repeat (3) step();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) step();
        rst_n = 1'b1;
        step();
        tag = "R1";
        chk("R1 tx idle", tx_out, 1'b1);
        chk("R1 hold_empty", hold_empty, 1'b1);
        chk("R1 all_empty", all_empty, 1'b1);

        // R8 R9 R11: status timing around a single write
        tag = "R8";
        line_ctrl = 7'h03;
        send(8'hA5);
        chk("R8 hold_empty after write", hold_empty, 1'b0);
        chk("R9 all_empty after write", all_empty, 1'b0);
        step();
        chk("R8 hold_empty after move", hold_empty, 1'b1);
        chk("R9 all_empty while shifting", all_empty, 1'b0);
        chk("R11 start bit without tick wait", tx_out, 1'b0);
        drain();
        chk("R9 all_empty after frame", all_empty, 1'b1);

        // R2: sparse ticks stretch the frame
        tag = "R2";
        tick_per = 3;
        send(8'h3C);
        drain();
        tick_per = 1;

        // R3: each word length
        tag = "R3";
        for (int w = 0; w < 4; w++) begin
            line_ctrl = 7'(w);
            send(8'hB6);
            drain();
        end

        // R4: long stop with 5-bit and 7-bit words
        tag = "R4";
        line_ctrl = 7'h04;
        send(8'h15); send(8'h0A);
        drain();
        line_ctrl = 7'h06;
        send(8'h55); send(8'h2A);
        drain();

        // R5: every parity setting on odd and even weight data
        tag = "R5";
        for (int pm = 0; pm < 8; pm++) begin
            line_ctrl = 7'h03 | 7'(pm << 3);
            send(8'h07);
            drain();
            send(8'h03);
            drain();
        end

        // R6: break raised in the middle of a frame
        tag = "R6";
        line_ctrl = 7'h03;
        send(8'hFF);
        repeat (60) step();
        line_ctrl[6] = 1'b1;
        step();
        chk("R6 break forces low", tx_out, 1'b0);
        repeat (80) step();
        line_ctrl[6] = 1'b0;
        step();
        chk("R6 release shows data level", tx_out, 1'b1);
        drain();

        // R7: format changed while a character is in flight
        tag = "R7";
        line_ctrl = 7'h03;
        send(8'h0F);
        repeat (20) step();
        line_ctrl = 7'h1C;
        send(8'h13);
        drain();

        // R10: single register, second and third writes collide
        tag = "R10";
        fifo_mode = 1'b0;
        line_ctrl = 7'h00;
        falls = 0;
        send(8'h00);
        send(8'h00);
        repeat (10) step();
        send(8'h00);
        send(8'h00);
        chk("R10 held byte blocks write", hold_empty, 1'b0);
        drain();
        checks++;
        if (falls != 2) begin
            errors++;
            $display("FAIL R10 register mode frames: actual %0d expected %0d", falls, 2);
        end

        // R10: queue order with distinct data
        fifo_mode = 1'b1;
        line_ctrl = 7'h0B;
        for (int i = 0; i < 6; i++) send(8'(8'h31 * i + 8'h4));
        drain();

        // R10: overfill the queue, count frames on the line
        line_ctrl = 7'h00;
        falls = 0;
        for (int i = 0; i < 40; i++) send(8'(i << 5));
        drain();
        checks++;
        if (falls != 33) begin
            errors++;
            $display("FAIL R10 queue mode frames: actual %0d expected %0d", falls, 33);
        end
        chk("R9 all_empty at end", all_empty, 1'b1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule